// File: doc/BRIEF.md
# Translation Buffer with Non-Faulting Probe Requests

This block is a small fully associative address translation buffer that serves four request kinds from one request port: an ordinary load, a probe that only asks whether a virtual page is currently held in the buffer, a probe that may fetch the mapping from a page walker and reports whether one exists, and a tentative load. The tentative load returns data with a success flag when it can translate and read the page. When it cannot, it returns a cleared flag and a zero value and raises no exception. A per-request selector can also make it give up on a buffer miss without starting a walk.

Translation misses go out on a page-walk request/response port. A walk that finds a valid mapping installs it into the buffer before the request that caused the walk completes, and the slot to overwrite is chosen in rotating order. Reads go out on a data-read port with one cycle of latency. Results come back on a response port that carries a success flag, a fault flag, the data, and zero and sign flags for returned data. Only one request is in flight at a time.

Top module: `xlat_probe_tlb`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, walk_req_valid and mem_rd_en are 0, and the buffer holds no mappings, so a hit probe on any page misses.
- R2: Opcode 1 (hit probe) returns rsp_ok=1 only when the page is held in the buffer, never raises walk_req_valid or mem_rd_en, and returns rsp_fault=0 and rsp_data=0.
- R3: Opcode 2 (page probe) returns rsp_ok=1 without a walk on a buffer hit. On a miss it issues exactly one walk and returns rsp_ok equal to walk_rsp_found, with rsp_fault=0.
- R4: A walk that returns walk_rsp_found=1 installs the mapping before the response, so a later hit probe on that page hits. A walk that returns found=0 installs nothing.
- R5: A load (opcode 0) or tentative load (opcode 3) that translates and passes its permission check reads physical address {ppn, vaddr[PAGE_BITS-1:0]} once and returns rsp_ok=1, rsp_fault=0 and rsp_data equal to the word read.
- R6: A tentative load whose walk finds no valid mapping returns rsp_ok=0, rsp_data=0 and rsp_fault=0, and does not read.
- R7: A tentative load with req_abort_on_miss=1 that misses the buffer issues no walk and no read and returns rsp_ok=0, rsp_data=0 and rsp_fault=0. The page is not installed.
- R8: A request with req_user=1 to a page whose mapping has the user bit clear fails its permission check: no read takes place and rsp_data is 0. For opcode 0 rsp_fault=1; for opcode 3 rsp_fault=0 and rsp_ok=0.
- R9: On a successful load of either kind, rsp_zf=1 exactly when rsp_data is 0 and rsp_sf equals rsp_data[DATA_W-1]. In all other responses both flags are 0.
- R10: An ordinary load whose walk finds no valid mapping returns rsp_fault=1, rsp_ok=0 and rsp_data=0.
- R11: req_ready is 0 from the cycle after a request is accepted until the response. rsp_valid and walk_req_valid are single-cycle pulses. A response arrives 2 cycles after acceptance for a buffer hit with no read, and 3 cycles after acceptance for a buffer hit with a read.
- R12: Installs fill slots in rotating order, so the install after ENTRIES installs evicts the oldest mapping and leaves the others in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 2 | 0 load, 1 hit probe, 2 page probe, 3 tentative load |
| req_vaddr | input | VA_W | Virtual address |
| req_user | input | 1 | Request made at user privilege |
| req_abort_on_miss | input | 1 | Tentative load gives up on a buffer miss instead of walking |
| walk_req_valid | output | 1 | Walk request pulse |
| walk_req_vpn | output | VA_W-PAGE_BITS | Virtual page to walk |
| walk_rsp_valid | input | 1 | Walk result present |
| walk_rsp_found | input | 1 | A valid mapping exists |
| walk_rsp_ppn | input | PA_W-PAGE_BITS | Physical page of the mapping |
| walk_rsp_user | input | 1 | Mapping is accessible at user privilege |
| mem_rd_en | output | 1 | Data read strobe |
| mem_rd_addr | output | PA_W | Physical read address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Success flag |
| rsp_fault | output | 1 | Fault raised by an ordinary load |
| rsp_data | output | DATA_W | Loaded data, zero when nothing was loaded |
| rsp_zf | output | 1 | Loaded data is zero |
| rsp_sf | output | 1 | Loaded data is negative |

## Verification
The requests follow a scripted history in which each page is met first as a miss and then as a hit, so every opcode is seen on both sides of the buffer. The page table in the bench mixes valid and invalid pages with user and supervisor pages. Each opcode is driven against each outcome: hit, walk found, walk not found, and permission failure. This separates results that come from the buffer from results that come from the walker, and it separates the tentative load's silent failure from the ordinary load's fault. The data words are chosen to include a zero word and a negative word so that the two flags are told apart. Counts of walks and reads per request, together with response latency, show where a probe must not walk or read. A run of installs past the buffer size checks that the oldest mapping is evicted and the others are kept.

// File: rtl/xpt_pkg.sv
// Shared types for the translation buffer with probe requests.
// Assumes a two-bit opcode field whose encoding is fixed at the port.
package xpt_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_QTLB  = 2'd1,
        OP_QPAGE = 2'd2,
        OP_TRY   = 2'd3
    } xpt_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WALK = 2'd2,
        ST_DATA = 2'd3
    } xpt_state_e;

    // True for opcodes that fetch data after translation
    function automatic logic op_reads(xpt_op_e op);
        return (op == OP_LOAD) || (op == OP_TRY);
    endfunction

endpackage

// File: rtl/xpt_xlat_array.sv
// Fully associative mapping store: compares the virtual page against all
// slots in parallel and fills slots in rotating order.
// Assumes a page is never filled while it is already present.
module xpt_xlat_array #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_user,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_user
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] slot_valid;
    logic [VPN_W-1:0]   slot_vpn  [ENTRIES];
    logic [PPN_W-1:0]   slot_ppn  [ENTRIES];
    logic [ENTRIES-1:0] slot_user;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   victim;

    // One comparator per slot
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = slot_valid[e] && (slot_vpn[e] == look_vpn);
    end

    assign hit = |match;

    // Merge the fields of the single matching slot
    always_comb begin
        hit_ppn  = '0;
        hit_user = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) begin
                hit_ppn  = hit_ppn | slot_ppn[e];
                hit_user = hit_user | slot_user[e];
            end
        end
    end

    // Valid bits and rotating victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= '0;
            victim     <= '0;
        end else if (fill_en) begin
            slot_valid[victim] <= 1'b1;
            victim <= (victim == LAST_IDX) ? '0 : victim + 1'b1;
        end
    end

    // Mapping payload, written only on fill
    always_ff @(posedge clk) begin
        if (fill_en) begin
            slot_vpn[victim]  <= fill_vpn;
            slot_ppn[victim]  <= fill_ppn;
            slot_user[victim] <= fill_user;
        end
    end

endmodule

// File: rtl/xpt_ctrl.sv
// Request sequencer: holds the accepted request, decides between answer,
// walk and read, and repeats the lookup once after a walk completes.
// Assumes one request in flight; the walker answers each request once.
module xpt_ctrl
    import xpt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  xpt_op_e                   req_op,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic                      req_user,
    input  logic                      req_abort_on_miss,
    output logic [VA_W-PAGE_BITS-1:0] look_vpn,
    input  logic                      hit,
    input  logic [PA_W-PAGE_BITS-1:0] hit_ppn,
    input  logic                      hit_user,
    output logic                      walk_req_valid,
    input  logic                      walk_rsp_valid,
    input  logic                      walk_rsp_found,
    output logic                      fill_en,
    output logic                      mem_rd_en,
    output logic [PA_W-1:0]           mem_rd_addr,
    output logic                      done,
    output logic                      done_ok,
    output logic                      done_fault,
    output logic                      done_take_data
);
    localparam int VPN_W = VA_W - PAGE_BITS;

    xpt_state_e            state, state_d;
    xpt_op_e               op_q;
    logic [VPN_W-1:0]      vpn_q;
    logic [PAGE_BITS-1:0]  off_q;
    logic                  user_q;
    logic                  abort_q;
    logic                  walked_q;
    logic                  perm_ok;
    logic                  give_up;

    assign req_ready   = (state == ST_IDLE);
    assign look_vpn    = vpn_q;
    assign mem_rd_addr = {hit_ppn, off_q};
    assign perm_ok     = hit_user || !user_q;
    assign give_up     = (op_q == OP_QTLB) || (op_q == OP_TRY && abort_q) || walked_q;

    // Next state and per-cycle strobes
    always_comb begin
        state_d        = state;
        walk_req_valid = 1'b0;
        fill_en        = 1'b0;
        mem_rd_en      = 1'b0;
        done           = 1'b0;
        done_ok        = 1'b0;
        done_fault     = 1'b0;
        done_take_data = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) state_d = ST_LOOK;
            ST_LOOK: begin
                if (hit) begin
                    if (!op_reads(op_q)) begin
                        done    = 1'b1;
                        done_ok = 1'b1;
                        state_d = ST_IDLE;
                    end else if (perm_ok) begin
                        mem_rd_en = 1'b1;
                        state_d   = ST_DATA;
                    end else begin
                        done       = 1'b1;
                        done_fault = (op_q == OP_LOAD);
                        state_d    = ST_IDLE;
                    end
                end else if (give_up) begin
                    done       = 1'b1;
                    done_fault = walked_q && (op_q == OP_LOAD);
                    state_d    = ST_IDLE;
                end else begin
                    walk_req_valid = 1'b1;
                    state_d        = ST_WALK;
                end
            end
            ST_WALK: if (walk_rsp_valid) begin
                fill_en = walk_rsp_found;
                state_d = ST_LOOK;
            end
            ST_DATA: begin
                done           = 1'b1;
                done_ok        = 1'b1;
                done_take_data = 1'b1;
                state_d        = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and walk-done marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            walked_q <= 1'b0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE && req_valid)
                walked_q <= 1'b0;
            else if (state == ST_WALK && walk_rsp_valid)
                walked_q <= 1'b1;
        end
    end

    // Capture of the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_LOAD;
            vpn_q   <= '0;
            off_q   <= '0;
            user_q  <= 1'b0;
            abort_q <= 1'b0;
        end else if (state == ST_IDLE && req_valid) begin
            op_q    <= req_op;
            vpn_q   <= req_vaddr[VA_W-1:PAGE_BITS];
            off_q   <= req_vaddr[PAGE_BITS-1:0];
            user_q  <= req_user;
            abort_q <= req_abort_on_miss;
        end
    end

endmodule

// File: rtl/xpt_rsp_fmt.sv
// Response stage: registers the outcome, zeroes data that was not loaded
// and derives the zero and sign flags from loaded data.
// Assumes done is a single-cycle strobe.
module xpt_rsp_fmt #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              done_ok,
    input  logic              done_fault,
    input  logic              done_take_data,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_zf,
    output logic              rsp_sf
);
    // Register the response fields once per completed request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_data  <= '0;
            rsp_zf    <= 1'b0;
            rsp_sf    <= 1'b0;
        end else begin
            rsp_valid <= done;
            if (done) begin
                rsp_ok    <= done_ok;
                rsp_fault <= done_fault;
                rsp_data  <= done_take_data ? mem_rd_data : '0;
                rsp_zf    <= done_take_data && (mem_rd_data == '0);
                rsp_sf    <= done_take_data && mem_rd_data[DATA_W-1];
            end
        end
    end

endmodule

// File: rtl/xlat_probe_tlb.sv
// Top level: translation buffer answering loads, hit probes, page probes and
// tentative loads; misses go to an external walker, data to a read port.
// Assumes a one-cycle read latency and a single outstanding request.
module xlat_probe_tlb
    import xpt_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = 24,
    parameter int DATA_W    = 32,
    parameter int ENTRIES   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_op,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic                      req_user,
    input  logic                      req_abort_on_miss,
    output logic                      walk_req_valid,
    output logic [VA_W-PAGE_BITS-1:0] walk_req_vpn,
    input  logic                      walk_rsp_valid,
    input  logic                      walk_rsp_found,
    input  logic [PA_W-PAGE_BITS-1:0] walk_rsp_ppn,
    input  logic                      walk_rsp_user,
    output logic                      mem_rd_en,
    output logic [PA_W-1:0]           mem_rd_addr,
    input  logic [DATA_W-1:0]         mem_rd_data,
    output logic                      rsp_valid,
    output logic                      rsp_ok,
    output logic                      rsp_fault,
    output logic [DATA_W-1:0]         rsp_data,
    output logic                      rsp_zf,
    output logic                      rsp_sf
);
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;

    logic [VPN_W-1:0] look_vpn;
    logic             hit;
    logic [PPN_W-1:0] hit_ppn;
    logic             hit_user;
    logic             fill_en;
    logic             done, done_ok, done_fault, done_take_data;

    assign walk_req_vpn = look_vpn;

    xpt_ctrl #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid         (req_valid),
        .req_ready         (req_ready),
        .req_op            (xpt_op_e'(req_op)),
        .req_vaddr         (req_vaddr),
        .req_user          (req_user),
        .req_abort_on_miss (req_abort_on_miss),
        .look_vpn          (look_vpn),
        .hit               (hit),
        .hit_ppn           (hit_ppn),
        .hit_user          (hit_user),
        .walk_req_valid    (walk_req_valid),
        .walk_rsp_valid    (walk_rsp_valid),
        .walk_rsp_found    (walk_rsp_found),
        .fill_en           (fill_en),
        .mem_rd_en         (mem_rd_en),
        .mem_rd_addr       (mem_rd_addr),
        .done              (done),
        .done_ok           (done_ok),
        .done_fault        (done_fault),
        .done_take_data    (done_take_data)
    );

    xpt_xlat_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_vpn  (look_vpn),
        .hit       (hit),
        .hit_ppn   (hit_ppn),
        .hit_user  (hit_user),
        .fill_en   (fill_en),
        .fill_vpn  (look_vpn),
        .fill_ppn  (walk_rsp_ppn),
        .fill_user (walk_rsp_user)
    );

    xpt_rsp_fmt #(.DATA_W(DATA_W)) u_fmt (
        .clk            (clk),
        .rst_n          (rst_n),
        .done           (done),
        .done_ok        (done_ok),
        .done_fault     (done_fault),
        .done_take_data (done_take_data),
        .mem_rd_data    (mem_rd_data),
        .rsp_valid      (rsp_valid),
        .rsp_ok         (rsp_ok),
        .rsp_fault      (rsp_fault),
        .rsp_data       (rsp_data),
        .rsp_zf         (rsp_zf),
        .rsp_sf         (rsp_sf)
    );

endmodule

// File: rtl/xpt_probe_checker.sv
// Port-level protocol checks for the translation buffer, bound to the top.
// Assumes the opcode seen at acceptance applies until the next acceptance.
module xpt_probe_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic              req_abort_on_miss,
    input logic              walk_req_valid,
    input logic              mem_rd_en,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              rsp_fault,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_zf,
    input logic              rsp_sf
);
    logic [1:0] cur_op;
    logic       cur_abort;

    // Remember the opcode of the request in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op    <= 2'd0;
            cur_abort <= 1'b0;
        end else if (req_valid && req_ready) begin
            cur_op    <= req_op;
            cur_abort <= req_abort_on_miss;
        end
    end

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r11_walk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |=> !walk_req_valid);
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r2_probe_never_walks: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> (cur_op != 2'd1));
    a_r7_abort_never_walks: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !(cur_op == 2'd3 && cur_abort));
    a_r5_reads_only_for_loads: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (cur_op == 2'd0 || cur_op == 2'd3));
    a_r6_failure_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_data == '0 && !rsp_zf && !rsp_sf));
    a_r8_fault_only_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (cur_op == 2'd0 && !rsp_ok));

endmodule

bind xlat_probe_tlb xpt_probe_checker #(.DATA_W(DATA_W)) u_probe_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_ready         (req_ready),
    .req_op            (req_op),
    .req_abort_on_miss (req_abort_on_miss),
    .walk_req_valid    (walk_req_valid),
    .mem_rd_en         (mem_rd_en),
    .rsp_valid         (rsp_valid),
    .rsp_ok            (rsp_ok),
    .rsp_fault         (rsp_fault),
    .rsp_data          (rsp_data),
    .rsp_zf            (rsp_zf),
    .rsp_sf            (rsp_sf)
);

// File: tb/tb_xlat_probe_tlb.sv
// Self-checking bench: a vector table of requests with expected outcomes,
// then directed tests for slot rotation and reset.
module tb_xlat_probe_tlb;
    localparam int VA_W = 32, PAGE_BITS = 12, PA_W = 24, DATA_W = 32, ENTRIES = 4;
    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_user = 1'b0, req_abort_on_miss = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_ready, walk_req_valid, mem_rd_en;
    logic [VPN_W-1:0] walk_req_vpn;
    logic walk_rsp_valid = 1'b0, walk_rsp_found = 1'b0, walk_rsp_user = 1'b0;
    logic [PPN_W-1:0] walk_rsp_ppn = '0;
    logic [PA_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic rsp_valid, rsp_ok, rsp_fault, rsp_zf, rsp_sf;
    logic [DATA_W-1:0] rsp_data;

    int n_checks = 0, n_fail = 0, walk_count = 0, rd_count = 0;

    always #5 clk = ~clk;

    xlat_probe_tlb #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W),
                     .DATA_W(DATA_W), .ENTRIES(ENTRIES)) dut (.*);

    // Bench page table: valid unless vpn[1:0]==3, user page when vpn[2]==0
    function automatic logic pt_found(input logic [7:0] v); return v[1:0] != 2'b11; endfunction
    function automatic logic pt_user(input logic [7:0] v); return !v[2]; endfunction
    function automatic logic [PPN_W-1:0] pt_ppn(input logic [7:0] v);
        return {4'h0, v} ^ 12'hA5C;
    endfunction
    function automatic logic [DATA_W-1:0] mem_word(input logic [PA_W-1:0] pa);
        return (pa[3:0] == 4'h0) ? '0 : {pa[4], 7'h0, pa};
    endfunction

    // Walker model: answers two cycles after the request
    initial forever begin
        @(negedge clk);
        if (walk_req_valid) begin
            logic [7:0] v;
            v = walk_req_vpn[7:0];
            walk_count++;
            repeat (2) @(negedge clk);
            walk_rsp_valid = 1'b1;
            walk_rsp_found = pt_found(v);
            walk_rsp_user  = pt_user(v);
            walk_rsp_ppn   = pt_ppn(v);
            @(negedge clk);
            walk_rsp_valid = 1'b0;
        end
    end

    // Data memory model: word is ready the cycle after the strobe
    initial forever begin
        @(negedge clk);
        if (mem_rd_en) begin
            rd_count++;
            mem_rd_data = mem_word(mem_rd_addr);
        end
    end

    task automatic check(input bit good, input int tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Issue one request and compare every response field
    task automatic expect_req(input logic [1:0] op, input logic [7:0] vpn,
                              input logic [11:0] off, input logic user, input logic abort,
                              input logic e_ok, input logic e_fault, input logic e_walk,
                              input logic e_rd, input int tag);
        int w0, r0, lat;
        logic [DATA_W-1:0] e_data;
        logic busy;
        w0 = walk_count; r0 = rd_count;
        e_data = e_rd ? mem_word({pt_ppn(vpn), off}) : '0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_user = user; req_abort_on_miss = abort;
        req_vaddr = {12'h0, vpn, off};
        @(negedge clk);
        req_valid = 1'b0;
        busy = req_ready;
        lat = 1;
        while (!rsp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        check(!busy, 11, "ready while busy (R11)", longint'(busy), 0);
        check(rsp_valid, tag, "response arrived", longint'(rsp_valid), 1);
        check(rsp_ok == e_ok, tag, "ok flag", longint'(rsp_ok), longint'(e_ok));
        check(rsp_fault == e_fault, tag, "fault flag", longint'(rsp_fault), longint'(e_fault));
        check(rsp_data == e_data, tag, "data", longint'(rsp_data), longint'(e_data));
        // R9: flags follow loaded data only
        check(rsp_zf == (e_rd && e_data == 0), 9, "zero flag", longint'(rsp_zf),
              longint'(e_rd && e_data == 0));
        check(rsp_sf == (e_rd && e_data[DATA_W-1]), 9, "sign flag", longint'(rsp_sf),
              longint'(e_rd && e_data[DATA_W-1]));
        check((walk_count - w0) == int'(e_walk), tag, "walk count",
              longint'(walk_count - w0), longint'(e_walk));
        check((rd_count - r0) == int'(e_rd), tag, "read count",
              longint'(rd_count - r0), longint'(e_rd));
        if (!e_walk)  // R11: hit latency
            check(lat == (e_rd ? 3 : 2), 11, "latency", longint'(lat), e_rd ? 3 : 2);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  vpn;
        logic [11:0] off;
        logic        user;
        logic        abort;
        logic        ok;
        logic        fault;
        logic        walk;
        logic        rd;
        logic [3:0]  tag;
    } vec_t;

    // op, vpn, offset, user, abort, ok, fault, walk, read, requirement
    localparam vec_t VECS [14] = '{
        '{2'd1, 8'h01, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 probe miss
        '{2'd2, 8'h01, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 walk found
        '{2'd1, 8'h01, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 installed
        '{2'd2, 8'h03, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 walk not found
        '{2'd1, 8'h03, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 nothing installed
        '{2'd3, 8'h02, 12'h010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 zero word
        '{2'd3, 8'h02, 12'h01F, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 negative word
        '{2'd0, 8'h04, 12'h008, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 load faults
        '{2'd3, 8'h04, 12'h008, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 silent
        '{2'd0, 8'h04, 12'h024, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 plain load
        '{2'd3, 8'h05, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 abort on miss
        '{2'd1, 8'h05, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 not installed
        '{2'd3, 8'h07, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 no mapping
        '{2'd0, 8'h0B, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd10}  // R10 load faults
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready, 1, "ready in reset", longint'(req_ready), 1);
        check(!rsp_valid && !walk_req_valid && !mem_rd_en, 1, "strobes in reset",
              longint'({rsp_valid, walk_req_valid, mem_rd_en}), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 14; i++)
            expect_req(VECS[i].op, VECS[i].vpn, VECS[i].off, VECS[i].user, VECS[i].abort,
                       VECS[i].ok, VECS[i].fault, VECS[i].walk, VECS[i].rd, int'(VECS[i].tag));

        // R12: slots hold 1,2,4; fill 5 then 6 evicts 1
        expect_req(2'd2, 8'h05, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12);
        expect_req(2'd2, 8'h06, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12);
        expect_req(2'd1, 8'h01, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12);
        expect_req(2'd1, 8'h02, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12);
        // R12: next fill evicts 2, keeps 4
        expect_req(2'd2, 8'h08, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12);
        expect_req(2'd1, 8'h02, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12);
        expect_req(2'd1, 8'h04, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12);

        // R1: second reset empties the buffer
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid, 1, "idle after reset",
              longint'({req_ready, rsp_valid}), 2);
        rst_n = 1'b1;
        expect_req(2'd1, 8'h04, 12'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1);

        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

endmodule